// File: doc/BRIEF.md
# Programmable Divider and Timer Unit

This block is a byte-wide, memory-mapped timer for an 8-bit processor subsystem running from a 4.194304 MHz core clock. A free-running 16-bit prescaler counts every core clock. Its upper byte is visible as a divider register that advances at 16384 Hz. A programmable 8-bit counter advances on ticks taken from one of four prescaler taps, chosen by a 2-bit rate code. When it steps past 0xFF it takes its next value from a reload register and raises a one-cycle interrupt request. That request is meant for bit 2 of the system interrupt flag set.

Software reaches the four registers through a plain bus of an 8-bit low address, write data, a write strobe and combinational read data. The offsets are 0x04 (divider), 0x05 (counter), 0x06 (reload) and 0x07 (control). A tick is the falling edge of the selected tap ANDed with the enable bit. As a result, clearing the prescaler or disabling the counter while the tap is high produces one extra count.

Top module: `tmr_unit`

## Requirements
- R1: After reset, offsets 0x04, 0x05, 0x06 and 0x07 all read 0x00 and `timer_irq` is low.
- R2: The byte at offset 0x04 reads bits 15:8 of a prescaler that increments on every clock, so it advances once per 256 clocks.
- R3: Any write to offset 0x04 clears the whole prescaler to zero, whatever the write data; the divider reads 0x00 right after the write edge.
- R4: Control bits 1:0 choose the counter period in clocks: code 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256. After a divider write at edge E, with the counter enabled before the tap first rises, the counter has advanced floor((c-1)/P) times after edge E+c.
- R5: With control bit 2 clear, the counter holds its value no matter how long the prescaler runs.
- R6: A tick with the counter at 0xFF loads the reload value (offset 0x06) at that edge. `timer_irq` is high for exactly the one cycle in which the counter first shows the reload value.
- R7: Ticks are falling edges of (selected tap AND enable). A divider write, or clearing the enable bit, while the selected tap is 1 advances the counter by one, one edge later.
- R8: Offsets 0x05 and 0x06 read back the last written byte. Offset 0x07 reads the written bits 2:0 with bits 7:3 as zero. Any other offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| timer_irq | output | 1 | One-cycle timer interrupt request |

## Verification
A prescaler that is off by one shows up within one clock in the divider's upper byte only every 256 clocks. It shifts every counter tick by one cycle, however, and the bench exposes that by sampling exactly on each side of a tick edge for all four rate codes. A wrong tap or a lost edge memory appears at the counter port one edge after the divider write or enable clear that should have produced the extra tick. A bad reload or a stretched request is visible in the single cycle after the 0xFF tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;

  // prescaler bit whose falling edge paces the counter for a rate code
  function automatic int tap_bit(input logic [1:0] sel);
    return (sel == 2'b00) ? 9 : (2 * int'(sel) + 1);
  endfunction

  // counter step: wraps through the reload value
  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] reload);
    return (&cur) ? reload : cur + 1'b1;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  output logic [PRESC_W-1:0] presc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     presc <= '0;
    else if (clear) presc <= '0;
    else            presc <= presc + 1'b1;
  end
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic [1:0]         rate_sel,
  input  logic               enable,
  output logic               tick
);
  localparam int TAP_W = $clog2(PRESC_W);

  logic [TAP_W-1:0] tap;
  logic             gated;
  logic             gated_q;

  assign tap   = TAP_W'(tmr_pkg::tap_bit(rate_sel));
  assign gated = presc[tap] & enable;
  assign tick  = gated_q & ~gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gated_q <= 1'b0;
    else        gated_q <= gated;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic         mod_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] reload,
  output logic         wrap,
  output logic         irq
);
  assign wrap = tick & (&cnt) & ~cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
      irq    <= 1'b0;
    end else begin
      if (cnt_wr)    cnt <= wdata;
      else if (tick) cnt <= tmr_pkg::count_step(cnt, reload);
      if (mod_wr) reload <= wdata;
      irq <= wrap;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int PRESC_W  = 16,
  parameter int DIV_LSB  = 8,
  parameter int ADDR_W   = 8,
  parameter logic [7:0] OFF_DIV  = 8'h04,
  parameter logic [7:0] OFF_CNT  = 8'h05,
  parameter logic [7:0] OFF_MOD  = 8'h06,
  parameter logic [7:0] OFF_CTRL = 8'h07
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [tmr_pkg::DATA_W-1:0]  bus_wdata,
  input  logic                        bus_we,
  output logic [tmr_pkg::DATA_W-1:0]  bus_rdata,
  output logic                        timer_irq
);
  localparam int DW = tmr_pkg::DATA_W;

  logic [PRESC_W-1:0] presc;
  logic [2:0]         ctrl_q;
  logic [DW-1:0]      cnt_q;
  logic [DW-1:0]      mod_q;
  logic               div_wr, cnt_wr, mod_wr, ctrl_wr;
  logic               tick, wrap;

  assign div_wr  = bus_we & (bus_addr == ADDR_W'(OFF_DIV));
  assign cnt_wr  = bus_we & (bus_addr == ADDR_W'(OFF_CNT));
  assign mod_wr  = bus_we & (bus_addr == ADDR_W'(OFF_MOD));
  assign ctrl_wr = bus_we & (bus_addr == ADDR_W'(OFF_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[2:0];
  end

  tmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(div_wr), .presc(presc)
  );

  tmr_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .presc(presc),
    .rate_sel(ctrl_q[1:0]), .enable(ctrl_q[2]), .tick(tick)
  );

  tmr_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .mod_wr(mod_wr),
    .wdata(bus_wdata), .cnt(cnt_q), .reload(mod_q), .wrap(wrap), .irq(timer_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_DIV))       bus_rdata = presc[DIV_LSB +: DW];
    else if (bus_addr == ADDR_W'(OFF_CNT))  bus_rdata = cnt_q;
    else if (bus_addr == ADDR_W'(OFF_MOD))  bus_rdata = mod_q;
    else if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = {{(DW-3){1'b0}}, ctrl_q};
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int PRESC_W = 16,
  parameter int W       = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PRESC_W-1:0] presc,
  input logic               div_wr,
  input logic               tick,
  input logic               wrap,
  input logic               cnt_wr,
  input logic [W-1:0]       cnt,
  input logic [W-1:0]       reload,
  input logic               irq
);
  // R2
  presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wr |=> presc == $past(presc) + 1'b1);
  // R3
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> presc == '0);
  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));
  // R6
  reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == $past(reload));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> irq);
  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind tmr_unit tmr_unit_chk #(.PRESC_W(PRESC_W), .W(tmr_pkg::DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .presc(presc), .div_wr(div_wr), .tick(tick),
  .wrap(wrap), .cnt_wr(cnt_wr), .cnt(cnt_q), .reload(mod_q), .irq(timer_irq)
);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       timer_irq;

  int tests = 0;
  int fails = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  tmr_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .timer_irq(timer_irq)
  );

  // rate vectors: code, clocks after divider write, expected count
  localparam int VN = 9;
  localparam int V_SEL [VN] = '{1, 1, 1, 2, 2, 2, 3, 0, 0};
  localparam int V_CLK [VN] = '{16, 17, 49, 64, 65, 129, 257, 1024, 1025};
  localparam int V_EXP [VN] = '{0, 1, 3, 0, 1, 2, 1, 0, 1};

  function automatic int period_of(input int sel);
    return (sel == 0) ? 1024 : (4 << (2 * sel));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counter = c0, reload = m, prescaler cleared at E, control written at E+1
  task automatic arm(input logic [7:0] ctl, input logic [7:0] c0, input logic [7:0] m);
    bus_write(8'h07, 8'h00);
    bus_write(8'h05, c0);
    bus_write(8'h06, m);
    bus_write(8'h04, 8'h00);
    bus_write(8'h07, ctl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    // R1 reset state
    read_reg(8'h04, rd); check("R1 div", rd, 0);
    read_reg(8'h05, rd); check("R1 cnt", rd, 0);
    read_reg(8'h06, rd); check("R1 mod", rd, 0);
    read_reg(8'h07, rd); check("R1 ctrl", rd, 0);
    check("R1 irq", timer_irq, 0);

    // R2 divider steps every 256 clocks
    bus_write(8'h04, 8'hA5);
    wait_clk(255);
    read_reg(8'h04, rd); check("R2 div before", rd, 0);
    wait_clk(1);
    read_reg(8'h04, rd); check("R2 div after", rd, 1);
    wait_clk(300);
    read_reg(8'h04, rd); check("R2 div later", rd, 2);
    // R3 any data clears
    bus_write(8'h04, 8'h5A);
    read_reg(8'h04, rd); check("R3 div clear", rd, 0);

    // R4 rate vectors
    for (int v = 0; v < VN; v++) begin
      arm(8'h04 | 8'(V_SEL[v]), 8'h00, 8'h00);
      wait_clk(V_CLK[v] - 1);
      read_reg(8'h05, rd);
      check($sformatf("R4 vec%0d", v), rd, V_EXP[v]);
      check($sformatf("R4 model%0d", v), V_EXP[v], (V_CLK[v] - 1) / period_of(V_SEL[v]));
    end

    // R5 disabled counter holds
    arm(8'h03, 8'h10, 8'h00);
    wait_clk(2100);
    read_reg(8'h05, rd); check("R5 hold", rd, 8'h10);
    check("R5 irq", timer_irq, 0);

    // R6 overflow reload and pulse
    arm(8'h05, 8'hFE, 8'h40);
    wait_clk(31);
    read_reg(8'h05, rd); check("R6 at FF", rd, 8'hFF);
    check("R6 irq low", timer_irq, 0);
    wait_clk(1);
    read_reg(8'h05, rd); check("R6 reload", rd, 8'h40);
    check("R6 irq high", timer_irq, 1);
    wait_clk(1);
    check("R6 irq one cycle", timer_irq, 0);
    read_reg(8'h05, rd); check("R6 cnt kept", rd, 8'h40);

    // R7 divider write while tap high
    arm(8'h05, 8'h00, 8'h00);
    wait_clk(9);
    bus_write(8'h04, 8'h00);
    read_reg(8'h05, rd); check("R7 div edge before", rd, 0);
    wait_clk(1);
    read_reg(8'h05, rd); check("R7 div edge tick", rd, 1);

    // R7 disable while tap high, then R5 hold
    arm(8'h05, 8'h00, 8'h00);
    wait_clk(9);
    bus_write(8'h07, 8'h01);
    wait_clk(1);
    read_reg(8'h05, rd); check("R7 disable tick", rd, 1);
    wait_clk(40);
    read_reg(8'h05, rd); check("R5 hold after disable", rd, 1);

    // R8 read-back
    bus_write(8'h06, 8'h3C);
    read_reg(8'h06, rd); check("R8 mod", rd, 8'h3C);
    bus_write(8'h05, 8'hC3);
    read_reg(8'h05, rd); check("R8 cnt", rd, 8'hC3);
    bus_write(8'h07, 8'hF8);
    read_reg(8'h07, rd); check("R8 ctrl zero", rd, 8'h00);
    bus_write(8'h07, 8'hFB);
    read_reg(8'h07, rd); check("R8 ctrl bits", rd, 8'h03);
    read_reg(8'h03, rd); check("R8 unmapped", rd, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule